// File: doc/BRIEF.md
# One-Time-Programmable Byte Store

This block is a synthesizable behavioural core of a byte-wide memory that can be written only once per bit. Three active-low controls run it. The chip select `ce_n` powers the part up. The output gate `oe_n` lets data onto the bus. The burn strobe `pgm_n` writes a location. A single-bit flag `hv_en` stands in for the high programming voltage, and a second flag, `sig_en`, switches the read path to two fixed identifier bytes. All analog conditions are reduced to these flags. The bidirectional data pins are split into `din`, `dout` and a drive enable `dout_en`, so the block has no internal tri-states.

Reset represents the erased part: every bit reads 1. A burn pulse can only clear bits. The stored byte becomes the old byte ANDed with `din`. A host programs a location by dropping `pgm_n` while `ce_n` is low and `hv_en` is set. It then checks the location by reading it back with the strobe high and the voltage flag still set. Programming tools use signature mode to identify the part.

Top module: `otp_byte_store`

## Requirements
- R1: `dout_en` is 1 only when `ce_n` = 0, `oe_n` = 0 and `pgm_n` = 1. When `dout_en` is 0, `dout` is 8'h00.
- R2: While `ce_n` = 1 (standby), `dout_en` is 0 whatever `oe_n` is.
- R3: After reset every location reads 8'hFF.
- R4: A burn replaces the stored byte with (old AND `din`). A bit that is 0 never reads 1 again.
- R5: A burn happens once per strobe, at the first rising clock edge that sees `pgm_n` = 0 after it was 1. The burn uses the `addr` and `din` present at that edge. Holding the strobe low writes nothing further.
- R6: While `ce_n` = 1 a falling strobe writes nothing.
- R7: While `hv_en` = 0 a falling strobe writes nothing.
- R8: A read with `hv_en` = 1, `pgm_n` = 1 and both enables low (verify) returns the stored byte.
- R9: With `sig_en` = 1 and all address bits above bit 0 zero, the read returns parameter MFR_ID (default 8'h20) when `addr[0]` = 0 and DEV_ID (default 8'h61) when `addr[0]` = 1.
- R10: With `sig_en` = 1 and any address bit above bit 0 set, the read returns 8'h00.
- R11: Signature reads leave the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (erased state) |
| ce_n | input | 1 | Chip select, active low; high means standby |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Burn strobe, active low |
| hv_en | input | 1 | Programming-voltage present flag |
| sig_en | input | 1 | Signature-mode flag |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data applied for a burn |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Data bus drive enable |

## Verification
The bench burns a location twice with overlapping patterns and then with all ones. A design that stored `din` directly, or ORed it in, would show bits coming back. It holds the strobe low across an address change. A level-triggered write would corrupt the second location. It pulses the strobe with the chip deselected, and again with the voltage flag clear. Any leak in either gate would clear bits in a location that should stay erased. In signature mode it reads both identifiers and addresses with upper bits set, which catches a mux that ignores the upper bits. Afterwards it reads the array again, which catches any signature access that disturbed storage.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef logic [7:0] byte_t;

  // Burning can only pull bits low.
  function automatic byte_t burn_merge(input byte_t prior, input byte_t applied);
    return prior & applied;
  endfunction

  // Signature byte chosen by address bit 0; stray upper bits yield zero.
  function automatic byte_t ident_pick(input logic sel_dev, input logic upper_clear,
                                       input byte_t mfr, input byte_t dev);
    if (!upper_clear) return 8'h00;
    return sel_dev ? dev : mfr;
  endfunction
endpackage

// File: rtl/otp_strobe_edge.sv
module otp_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b1;
    else        strobe_q <= strobe_n;
  end

  assign fall = strobe_q & ~strobe_n;
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  byte_t             wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output byte_t             rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  byte_t cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (wr_en) begin
      cells[wr_addr] <= burn_merge(cells[wr_addr], wr_data);
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/otp_read_path.sv
module otp_read_path
  import otp_pkg::*;
#(
  parameter int    ADDR_W = 8,
  parameter byte_t MFR_ID = 8'h20,
  parameter byte_t DEV_ID = 8'h61
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              sig_en,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             cell_q,
  output byte_t             dout,
  output logic              dout_en
);
  logic  upper_clear;
  byte_t ident;
  byte_t sel_q;

  generate
    if (ADDR_W > 1) begin : g_upper
      assign upper_clear = (addr[ADDR_W-1:1] == '0);
    end else begin : g_single
      assign upper_clear = 1'b1;
    end
  endgenerate

  assign ident   = ident_pick(addr[0], upper_clear, MFR_ID, DEV_ID);
  assign sel_q   = sig_en ? ident : cell_q;
  assign dout_en = ~ce_n & ~oe_n & pgm_n;
  assign dout    = dout_en ? sel_q : 8'h00;
endmodule

// File: rtl/otp_byte_store.sv
module otp_byte_store
  import otp_pkg::*;
#(
  parameter int    ADDR_W = 8,
  parameter byte_t MFR_ID = 8'h20,
  parameter byte_t DEV_ID = 8'h61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              hv_en,
  input  logic              sig_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);
  logic  strobe_fall;
  logic  wr_fire;
  byte_t array_q;

  otp_strobe_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (pgm_n),
    .fall     (strobe_fall)
  );

  // Burn only when selected and high voltage is present.
  assign wr_fire = strobe_fall & ~ce_n & hv_en;

  otp_cell_array #(.ADDR_W(ADDR_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire),
    .wr_addr (addr),
    .wr_data (din),
    .rd_addr (addr),
    .rd_data (array_q)
  );

  otp_read_path #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_read (
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .pgm_n   (pgm_n),
    .sig_en  (sig_en),
    .addr    (addr),
    .cell_q  (array_q),
    .dout    (dout),
    .dout_en (dout_en)
  );
endmodule

// File: rtl/otp_byte_store_chk.sv
module otp_byte_store_chk #(
  parameter int         ADDR_W = 8,
  parameter logic [7:0] MFR_ID = 8'h20,
  parameter logic [7:0] DEV_ID = 8'h61
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pgm_n,
  input logic              hv_en,
  input logic              sig_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dout,
  input logic              dout_en,
  input logic              wr_fire
);
  a_r1_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!ce_n && !oe_n && pgm_n));

  a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);

  a_r4_no_regrow: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && $past(dout_en) && !sig_en && !$past(sig_en) && $stable(addr))
      |-> ((dout & ~$past(dout)) == 8'h00));

  a_r5_one_burn: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);

  a_r6_select_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !ce_n);

  a_r7_voltage_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> hv_en);

  a_r9_maker_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && sig_en && addr == '0) |-> (dout == MFR_ID));
endmodule

bind otp_byte_store otp_byte_store_chk #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce_n    (ce_n),
  .oe_n    (oe_n),
  .pgm_n   (pgm_n),
  .hv_en   (hv_en),
  .sig_en  (sig_en),
  .addr    (addr),
  .dout    (dout),
  .dout_en (dout_en),
  .wr_fire (wr_fire)
);

// File: tb/otp_byte_store_test.sv
`timescale 1ns/1ps
module otp_byte_store_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1;
  logic       oe_n = 1'b1;
  logic       pgm_n = 1'b1;
  logic       hv_en = 1'b0;
  logic       sig_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] din = 8'hFF;
  logic [7:0] dout;
  logic       dout_en;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  otp_byte_store uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .hv_en(hv_en), .sig_en(sig_en), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic s, output logic [7:0] q, output logic e);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; pgm_n = 1'b1; sig_en = s; addr = a;
    #1;
    q = dout; e = dout_en;
  endtask

  task automatic burn(input logic [7:0] a, input logic [7:0] d, input logic sel_n, input logic hv);
    @(negedge clk);
    oe_n = 1'b1; sig_en = 1'b0; ce_n = sel_n; hv_en = hv; addr = a; din = d; pgm_n = 1'b0;
    @(negedge clk);
    pgm_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b0; hv_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] q; logic e;
    rd(8'h00, 1'b0, q, e); check("R3 loc00", q, 8'hFF); check("R1 enable on read", {7'd0, e}, 8'h01);
    rd(8'h5A, 1'b0, q, e); check("R3 loc5A", q, 8'hFF);
    rd(8'hFF, 1'b0, q, e); check("R3 locFF", q, 8'hFF);
  endtask

  task automatic t_gating;
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; pgm_n = 1'b1; #1;
    check("R1 oe high", {7'd0, dout_en}, 8'h00);
    check("R1 dout idle", dout, 8'h00);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; #1;
    check("R2 standby oe low", {7'd0, dout_en}, 8'h00);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; #1;
    check("R2 standby oe high", {7'd0, dout_en}, 8'h00);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; hv_en = 1'b0; pgm_n = 1'b0; #1;
    check("R1 strobe low", {7'd0, dout_en}, 8'h00);
    @(negedge clk); pgm_n = 1'b1;
  endtask

  task automatic t_program;
    logic [7:0] q; logic e;
    burn(8'h05, 8'hA5, 1'b0, 1'b1);
    rd(8'h05, 1'b0, q, e); check("R4 first burn", q, 8'hA5);
    burn(8'h05, 8'h0F, 1'b0, 1'b1);
    rd(8'h05, 1'b0, q, e); check("R4 and merge", q, 8'h05);
    burn(8'h05, 8'hFF, 1'b0, 1'b1);
    rd(8'h05, 1'b0, q, e); check("R4 no regrow", q, 8'h05);
    rd(8'h06, 1'b0, q, e); check("R4 neighbour", q, 8'hFF);
  endtask

  task automatic t_verify;
    logic [7:0] q; logic e;
    burn(8'h09, 8'h3C, 1'b0, 1'b1);
    @(negedge clk); hv_en = 1'b1;
    rd(8'h09, 1'b0, q, e);
    check("R8 verify data", q, 8'h3C);
    check("R8 verify drive", {7'd0, e}, 8'h01);
    @(negedge clk); hv_en = 1'b0;
  endtask

  task automatic t_inhibit;
    logic [7:0] q; logic e;
    burn(8'h14, 8'h00, 1'b1, 1'b1);
    rd(8'h14, 1'b0, q, e); check("R6 deselected", q, 8'hFF);
    burn(8'h15, 8'h00, 1'b0, 1'b0);
    rd(8'h15, 1'b0, q, e); check("R7 no voltage", q, 8'hFF);
  endtask

  task automatic t_single;
    logic [7:0] q; logic e;
    @(negedge clk);
    oe_n = 1'b1; ce_n = 1'b0; hv_en = 1'b1; addr = 8'h1E; din = 8'h00; pgm_n = 1'b0;
    @(negedge clk); addr = 8'h1F;
    @(negedge clk); @(negedge clk); pgm_n = 1'b1;
    @(negedge clk); hv_en = 1'b0;
    rd(8'h1E, 1'b0, q, e); check("R5 first address", q, 8'h00);
    rd(8'h1F, 1'b0, q, e); check("R5 held strobe", q, 8'hFF);
  endtask

  task automatic t_signature;
    logic [7:0] q; logic e;
    rd(8'h00, 1'b1, q, e); check("R9 maker", q, 8'h20);
    rd(8'h01, 1'b1, q, e); check("R9 device", q, 8'h61);
    rd(8'h02, 1'b1, q, e); check("R10 bit1 set", q, 8'h00);
    rd(8'h81, 1'b1, q, e); check("R10 bit7 set", q, 8'h00);
    rd(8'h00, 1'b0, q, e); check("R11 loc00 after", q, 8'hFF);
    rd(8'h05, 1'b0, q, e); check("R11 loc05 after", q, 8'h05);
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_gating;
    t_program;
    t_verify;
    t_inhibit;
    t_single;
    t_signature;
    finish_up;
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up;
  end
endmodule